// File: doc/BRIEF.md
# Arithmetic Logic Unit with Condition Flags

This block is the execute stage's arithmetic unit for a 32-bit load/store processor. It has two operating modes. In two-operand mode it forms `A op B`. In single-operand mode it forms `op A`. Each mode takes its own 4-bit operation code. Every result path is combinational, so the result, the destination write strobe, the proposed flag value and the flag write strobe all settle in the same cycle as the inputs.

The block also holds the 4-bit condition-code register that the processor's branch conditions read. An ALU command can update that register. Two mask commands can also change it in place, one by OR and one by AND. The carry used by add-with-carry and subtract-with-borrow is taken from this register.

A 2-bit command input selects the cycle's action:

| `cmd` | Action |
|---|---|
| `00` | idle |
| `01` | ALU operation |
| `10` | OR the mask into the flags |
| `11` | AND the mask into the flags |

Top module: `alu_flags_unit`

## Requirements
- R1: The flag register reads `{V,C,Z,N}`, with V at bit 3, C at bit 2, Z at bit 1 and N at bit 0. An active-low asynchronous reset clears all four flags to 0. For every operation that updates the flags, Z is 1 exactly when the flag value is zero, and N equals that value's bit 31.
- R2: In two-operand mode (`mode`=0) the arithmetic codes are:
  - `0000` gives A+B.
  - `0001` gives A+B+C.
  - `0010` gives A-B.
  - `0011` gives A-B-C.

  After add, C is the unsigned carry-out. After subtract, C=1 means an unsigned borrow. V is set on signed overflow. The result is written.
- R3: Two-operand code `1000` (compare) sets the flags exactly as A-B would. Code `1001` (test) sets the flags as A AND B would, with V=C=0. Neither code asserts `dest_we`, and both drive `result` to 0.
- R4: Two-operand codes `0100`, `0101` and `0110` give AND, OR and XOR, and clear V and C. Code `0111` copies B to `result` with `dest_we`=1, holds `flags_we` at 0 and leaves the flags unchanged.
- R5: Two-operand codes `1010` and `1011` give the 32-bit product of the low 16 bits of A and of B. Code `1010` treats those halves as unsigned and code `1011` as signed. Z and N come from the product, and V=C=0.
- R6: In single-operand mode (`mode`=1) the codes are:
  - `0000` gives A+1. C is the carry-out.
  - `0001` gives A-1. C is the borrow.
  - `0111` gives 0-A. C=1 unless A is 0.

  V marks signed overflow for all three.
- R7: Single-operand shifts move by one bit:
  - `0011` is a logic left shift.
  - `0100` is a logic right shift.
  - `0101` is an arithmetic left shift.
  - `0110` is an arithmetic right shift, which keeps bit 31.

  C receives the bit shifted out. V is 0, except that for the arithmetic left shift V=1 when bit 31 of the result differs from bit 31 of A.
- R8: Single-operand codes `0010` (NOT), `1000` (reverse the four bytes), `1010` (sign-extend bits 15:0) and `1011` (sign-extend bits 7:0) clear V and C. Code `1001` (compare with zero) sets Z and N from A and clears V and C. It does not assert `dest_we`.
- R9: Codes `1100` to `1111` in either mode drive `result` to 0, `dest_we` to 0 and `flags_we` to 0, and the flag register keeps its value.
- R10: Command `10` loads `flags | mask` and command `11` loads `flags & mask`, each with `flags_we`=1. Command `00` leaves the flags unchanged and keeps both write strobes at 0.
- R11: `result`, `dest_we`, `flags_new` and `flags_we` are combinational. `flags_new` equals the current flags whenever `flags_we` is 0. The flag register takes `flags_new` at the next rising clock edge. `dest_we` is 1 only under command `01`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | Command: 00 idle, 01 ALU, 10 OR mask, 11 AND mask |
| mode | input | 1 | 0 two-operand, 1 single-operand |
| op | input | 4 | Operation code for the selected mode |
| a | input | 32 | First operand |
| b | input | 32 | Second operand (two-operand mode only) |
| mask | input | 4 | Flag mask for commands 10 and 11 |
| result | output | 32 | Value for the destination register |
| dest_we | output | 1 | Destination write strobe |
| flags_new | output | 4 | Flag value to be loaded at the next edge |
| flags_we | output | 1 | Flag write strobe |
| flags | output | 4 | Current flag register `{V,C,Z,N}` |

## Verification
`result`, `dest_we`, `flags_new` and `flags_we` are due in the same cycle as the inputs. The bench therefore drives each command at a falling edge and samples these four outputs one time unit later, with no clock edge in between. The registered `flags` are due one rising edge later, and the bench samples them one time unit after that edge. Each ALU step is preceded by two mask commands, so every operation is swept with a known incoming carry and with the untouched flag bits in a known state.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_ALU  = 2'b01,
        CMD_FOR  = 2'b10,
        CMD_FAND = 2'b11
    } flag_cmd_e;

    // Bit order matters: V=3, C=2, Z=1, N=0
    typedef struct packed {
        logic v;
        logic c;
        logic z;
        logic n;
    } flag_t;

    localparam int FLAG_W = 4;

    // two-operand codes
    localparam logic [3:0] DY_ADD  = 4'h0;
    localparam logic [3:0] DY_ADC  = 4'h1;
    localparam logic [3:0] DY_SUB  = 4'h2;
    localparam logic [3:0] DY_SBB  = 4'h3;
    localparam logic [3:0] DY_AND  = 4'h4;
    localparam logic [3:0] DY_OR   = 4'h5;
    localparam logic [3:0] DY_XOR  = 4'h6;
    localparam logic [3:0] DY_CPY  = 4'h7;
    localparam logic [3:0] DY_CMP  = 4'h8;
    localparam logic [3:0] DY_TST  = 4'h9;
    localparam logic [3:0] DY_MULU = 4'hA;
    localparam logic [3:0] DY_MULS = 4'hB;

    // single-operand codes
    localparam logic [3:0] MO_INC  = 4'h0;
    localparam logic [3:0] MO_DEC  = 4'h1;
    localparam logic [3:0] MO_NOT  = 4'h2;
    localparam logic [3:0] MO_LSL  = 4'h3;
    localparam logic [3:0] MO_LSR  = 4'h4;
    localparam logic [3:0] MO_ASL  = 4'h5;
    localparam logic [3:0] MO_ASR  = 4'h6;
    localparam logic [3:0] MO_NEG  = 4'h7;
    localparam logic [3:0] MO_BSW  = 4'h8;
    localparam logic [3:0] MO_CMPZ = 4'h9;
    localparam logic [3:0] MO_SXW  = 4'hA;
    localparam logic [3:0] MO_SXB  = 4'hB;

endpackage

// File: rtl/alu_dyadic.sv
module alu_dyadic
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              wr,
    output logic              upd,
    output flag_t             fl
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    logic                     is_sub;
    logic [DATA_W-1:0]        addend;
    logic                     add_cin;
    logic [DATA_W:0]          sum;
    logic signed [DATA_W-1:0] sa;
    logic signed [DATA_W-1:0] sb;
    logic [DATA_W-1:0]        mul_u;
    logic [DATA_W-1:0]        mul_s;
    logic [DATA_W-1:0]        fval;

    // shared adder: subtraction adds the complement with inverted borrow
    always_comb begin
        is_sub = (op == DY_SUB) || (op == DY_SBB) || (op == DY_CMP);
        addend = is_sub ? ~b : b;
        case (op)
            DY_ADC:         add_cin = cin;
            DY_SUB, DY_CMP: add_cin = 1'b1;
            DY_SBB:         add_cin = ~cin;
            default:        add_cin = 1'b0;
        endcase
        sum = {1'b0, a} + {1'b0, addend} + {{DATA_W{1'b0}}, add_cin};
    end

    // half-width multiplies
    always_comb begin
        mul_u = {{HALF{1'b0}}, a[HALF-1:0]} * {{HALF{1'b0}}, b[HALF-1:0]};
        sa    = $signed({{HALF{a[HALF-1]}}, a[HALF-1:0]});
        sb    = $signed({{HALF{b[HALF-1]}}, b[HALF-1:0]});
        mul_s = sa * sb;
    end

    always_comb begin
        fval = '0;
        wr   = 1'b1;
        upd  = 1'b1;
        fl.v = 1'b0;
        fl.c = 1'b0;
        case (op)
            DY_ADD, DY_ADC, DY_SUB, DY_SBB, DY_CMP: begin
                fval = sum[MSB:0];
                fl.c = is_sub ? ~sum[DATA_W] : sum[DATA_W];
                fl.v = (a[MSB] == addend[MSB]) && (sum[MSB] != a[MSB]);
                wr   = (op != DY_CMP);
            end
            DY_AND, DY_TST: begin
                fval = a & b;
                wr   = (op != DY_TST);
            end
            DY_OR:   fval = a | b;
            DY_XOR:  fval = a ^ b;
            DY_CPY: begin
                fval = b;
                upd  = 1'b0;
            end
            DY_MULU: fval = mul_u;
            DY_MULS: fval = mul_s;
            default: begin
                wr  = 1'b0;
                upd = 1'b0;
            end
        endcase
        fl.z = (fval == '0);
        fl.n = fval[MSB];
        res  = wr ? fval : '0;
    end

    always_comb begin
        if (!$isunknown({op, a, b}) && op == DY_CMP)
            assert_cmp_borrow_R3: assert (fl.c == (a < b))
                else $error("compare borrow disagrees with unsigned order");
    end

endmodule

// File: rtl/alu_monadic.sv
module alu_monadic
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    output logic [DATA_W-1:0] res,
    output logic              wr,
    output logic              upd,
    output flag_t             fl
);
    localparam int HALF  = DATA_W / 2;
    localparam int MSB   = DATA_W - 1;
    localparam int BYTES = DATA_W / 8;

    logic [DATA_W-1:0] swapped;
    logic [DATA_W-1:0] fval;
    logic [DATA_W:0]   inc_s;
    logic [DATA_W-1:0] min_val;

    for (genvar i = 0; i < BYTES; i++) begin : g_bsw
        assign swapped[8*i +: 8] = a[8*(BYTES-1-i) +: 8];
    end

    always_comb begin
        min_val = {1'b1, {(DATA_W-1){1'b0}}};
        inc_s   = {1'b0, a} + {{DATA_W{1'b0}}, 1'b1};
        fval    = '0;
        wr      = 1'b1;
        upd     = 1'b1;
        fl.v    = 1'b0;
        fl.c    = 1'b0;
        case (op)
            MO_INC: begin
                fval = inc_s[MSB:0];
                fl.c = inc_s[DATA_W];
                fl.v = (a == ~min_val);
            end
            MO_DEC: begin
                fval = a - 1'b1;
                fl.c = (a == '0);
                fl.v = (a == min_val);
            end
            MO_NOT: fval = ~a;
            MO_LSL: begin
                fval = {a[MSB-1:0], 1'b0};
                fl.c = a[MSB];
            end
            MO_LSR: begin
                fval = {1'b0, a[MSB:1]};
                fl.c = a[0];
            end
            MO_ASL: begin
                fval = {a[MSB-1:0], 1'b0};
                fl.c = a[MSB];
                fl.v = a[MSB] ^ a[MSB-1];
            end
            MO_ASR: begin
                fval = {a[MSB], a[MSB:1]};
                fl.c = a[0];
            end
            MO_NEG: begin
                fval = '0 - a;
                fl.c = (a != '0);
                fl.v = (a == min_val);
            end
            MO_BSW:  fval = swapped;
            MO_CMPZ: begin
                fval = a;
                wr   = 1'b0;
            end
            MO_SXW:  fval = {{HALF{a[HALF-1]}}, a[HALF-1:0]};
            MO_SXB:  fval = {{(DATA_W-8){a[7]}}, a[7:0]};
            default: begin
                wr  = 1'b0;
                upd = 1'b0;
            end
        endcase
        fl.z = (fval == '0);
        fl.n = fval[MSB];
        res  = wr ? fval : '0;
    end

    always_comb begin
        if (!$isunknown({op, a}) && op == MO_NEG)
            assert_neg_sum_R6: assert ((res + a) == '0)
                else $error("negation does not cancel the operand");
    end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_flags_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  flag_t nxt,
    output flag_t q
);
    typedef struct packed {
        flag_t flags;
    } state_t;

    state_t st_d;
    state_t st_q;

    always_comb begin
        st_d = st_q;
        if (we)
            st_d.flags = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign q = st_q.flags;

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd,
    input  logic              mode,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [FLAG_W-1:0] mask,
    output logic [DATA_W-1:0] result,
    output logic              dest_we,
    output logic [FLAG_W-1:0] flags_new,
    output logic              flags_we,
    output logic [FLAG_W-1:0] flags
);
    logic [DATA_W-1:0] dy_res;
    logic [DATA_W-1:0] mo_res;
    logic              dy_wr;
    logic              mo_wr;
    logic              dy_upd;
    logic              mo_upd;
    flag_t             dy_fl;
    flag_t             mo_fl;
    flag_t             cur;
    flag_t             nxt_d;
    logic              we_d;
    flag_cmd_e         cmd_e;

    alu_dyadic #(.DATA_W(DATA_W)) u_dy (
        .op (op),
        .a  (a),
        .b  (b),
        .cin(cur.c),
        .res(dy_res),
        .wr (dy_wr),
        .upd(dy_upd),
        .fl (dy_fl)
    );

    alu_monadic #(.DATA_W(DATA_W)) u_mo (
        .op (op),
        .a  (a),
        .res(mo_res),
        .wr (mo_wr),
        .upd(mo_upd),
        .fl (mo_fl)
    );

    alu_flag_reg u_fr (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we_d),
        .nxt  (nxt_d),
        .q    (cur)
    );

    always_comb begin
        cmd_e   = flag_cmd_e'(cmd);
        result  = '0;
        dest_we = 1'b0;
        we_d    = 1'b0;
        nxt_d   = cur;
        case (cmd_e)
            CMD_ALU: begin
                result  = mode ? mo_res : dy_res;
                dest_we = mode ? mo_wr  : dy_wr;
                we_d    = mode ? mo_upd : dy_upd;
                if (we_d)
                    nxt_d = mode ? mo_fl : dy_fl;
            end
            CMD_FOR: begin
                we_d  = 1'b1;
                nxt_d = cur | mask;
            end
            CMD_FAND: begin
                we_d  = 1'b1;
                nxt_d = cur & mask;
            end
            default: ;
        endcase
    end

    assign flags_new = nxt_d;
    assign flags_we  = we_d;
    assign flags     = cur;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> flags == '0)
        else $error("flags not cleared by reset");

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'b00 |=> $stable(flags))
        else $error("flags moved on idle");

    assert_or_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'b10 |=> flags == ($past(flags) | $past(mask)))
        else $error("OR mask result wrong");

    assert_and_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'b11 |=> flags == ($past(flags) & $past(mask)))
        else $error("AND mask result wrong");

    assert_unused_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b01 && op[3:2] == 2'b11) |=> $stable(flags))
        else $error("unused code touched flags");

    assert_alu_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b01 && flags_we) |=> flags == $past(flags_new))
        else $error("flag register missed the proposed value");

    assert_dest_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 2'b01 |-> !dest_we)
        else $error("destination write outside ALU command");

endmodule

// File: tb/alu_flags_unit_test.sv
module alu_flags_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd = 2'b00;
    logic        mode = 1'b0;
    logic [3:0]  op = 4'h0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [3:0]  mask = '0;
    logic [31:0] result;
    logic        dest_we;
    logic [3:0]  flags_new;
    logic        flags_we;
    logic [3:0]  flags;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_flags_unit uut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .mode(mode), .op(op),
        .a(a), .b(b), .mask(mask), .result(result), .dest_we(dest_we),
        .flags_new(flags_new), .flags_we(flags_we), .flags(flags)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic m, input logic [3:0] o);
        if (o >= 4'hC) return "R9";
        if (!m) begin
            if (o <= 4'h3) return "R2";
            if (o <= 4'h7) return "R4";
            if (o <= 4'h9) return "R3";
            return "R5";
        end
        if (o == 4'h0 || o == 4'h1 || o == 4'h7) return "R6";
        if (o >= 4'h3 && o <= 4'h6) return "R7";
        return "R8";
    endfunction

    // Reference model built from the requirements with 64-bit arithmetic
    task automatic model(input logic m, input logic [3:0] o,
                         input logic [31:0] x, input logic [31:0] y,
                         input logic [3:0] cur,
                         output logic [31:0] e_res, output logic e_wr,
                         output logic e_upd, output logic [3:0] e_fl);
        longint ux, uy, sx, sy, s, ss, p;
        logic [31:0] val;
        logic c, v, ci;
        ux = longint'({32'b0, x});
        uy = longint'({32'b0, y});
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        ci = cur[2];
        val = '0; c = 0; v = 0; e_wr = 1; e_upd = 1; s = 0; ss = 0;
        if (!m) begin
            case (o)
                4'h0, 4'h1: begin
                    s = ux + uy + ((o == 4'h1) ? longint'(ci) : 0);
                    ss = sx + sy + ((o == 4'h1) ? longint'(ci) : 0);
                    val = s[31:0]; c = s[32];
                end
                4'h2, 4'h3, 4'h8: begin
                    s = ux - uy - ((o == 4'h3) ? longint'(ci) : 0);
                    ss = sx - sy - ((o == 4'h3) ? longint'(ci) : 0);
                    val = s[31:0]; c = (s < 0);
                    e_wr = (o != 4'h8);
                end
                4'h4, 4'h9: begin val = x & y; e_wr = (o != 4'h9); end
                4'h5: val = x | y;
                4'h6: val = x ^ y;
                4'h7: begin val = y; e_upd = 0; end
                4'hA: begin p = longint'(x[15:0]) * longint'(y[15:0]); val = p[31:0]; end
                4'hB: begin
                    p = longint'($signed(x[15:0])) * longint'($signed(y[15:0]));
                    val = p[31:0];
                end
                default: begin e_wr = 0; e_upd = 0; end
            endcase
            if (o <= 4'h3 || o == 4'h8)
                v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
        end else begin
            case (o)
                4'h0: begin s = ux + 1; ss = sx + 1; val = s[31:0]; c = s[32]; end
                4'h1: begin s = ux - 1; ss = sx - 1; val = s[31:0]; c = (s < 0); end
                4'h2: val = ~x;
                4'h3: begin val = x << 1; c = x[31]; end
                4'h4: begin val = x >> 1; c = x[0]; end
                4'h5: begin val = x << 1; c = x[31]; v = (val[31] != x[31]); end
                4'h6: begin val = $signed(x) >>> 1; c = x[0]; end
                4'h7: begin s = 0 - ux; ss = 0 - sx; val = s[31:0]; c = (s < 0); end
                4'h8: val = {x[7:0], x[15:8], x[23:16], x[31:24]};
                4'h9: begin val = x; e_wr = 0; end
                4'hA: val = {{16{x[15]}}, x[15:0]};
                4'hB: val = {{24{x[7]}}, x[7:0]};
                default: begin e_wr = 0; e_upd = 0; end
            endcase
            if (o == 4'h0 || o == 4'h1 || o == 4'h7)
                v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
        end
        e_res = e_wr ? val : '0;
        e_fl  = e_upd ? {v, c, (val == 0), val[31]} : cur;
    endtask

    task automatic step(input logic [1:0] c, input logic [3:0] mk);
        @(negedge clk);
        cmd = c; mask = mk;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] vals [0:11];
        logic [31:0] e_res;
        logic        e_wr, e_upd;
        logic [3:0]  e_fl, preset;
        vals[0] = 32'h0000_0000; vals[1]  = 32'h0000_0001; vals[2]  = 32'h0000_0002;
        vals[3] = 32'h7FFF_FFFF; vals[4]  = 32'h8000_0000; vals[5]  = 32'hFFFF_FFFF;
        vals[6] = 32'hFFFF_FFFE; vals[7]  = 32'h0000_FFFF; vals[8]  = 32'h0000_8000;
        vals[9] = 32'h1234_5678; vals[10] = 32'h0000_00FF; vals[11] = 32'h0000_0080;

        // R1: reset state
        #(CLK_PERIOD * 2 + 1);
        chk("R1", "flags in reset", {28'b0, flags}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "flags after reset release", {28'b0, flags}, 32'h0);

        // R10: idle, OR, AND
        @(negedge clk); cmd = 2'b00; #1;
        chk("R10", "idle flags_we", {31'b0, flags_we}, 32'h0);
        chk("R11", "idle dest_we", {31'b0, dest_we}, 32'h0);
        step(2'b10, 4'b1010);
        chk("R10", "OR into zero", {28'b0, flags}, 32'hA);
        step(2'b10, 4'b0101);
        chk("R10", "OR fills", {28'b0, flags}, 32'hF);
        step(2'b11, 4'b0110);
        chk("R10", "AND keeps C,Z", {28'b0, flags}, 32'h6);
        step(2'b00, 4'b1111);
        chk("R10", "idle holds", {28'b0, flags}, 32'h6);

        // Sweep both modes, all codes, operand pairs, carry in
        for (int m = 0; m < 2; m++) begin
            for (int o = 0; o < 16; o++) begin
                for (int i = 0; i < 12; i++) begin
                    for (int j = 0; j < 12; j++) begin
                        if (m == 1 && j > 1) continue;
                        for (int k = 0; k < 2; k++) begin
                            preset = (k == 1) ? 4'b0100 : 4'b1011;
                            step(2'b11, 4'b0000);
                            step(2'b10, preset);
                            chk("R10", "preset", {28'b0, flags}, {28'b0, preset});
                            @(negedge clk);
                            cmd = 2'b01; mode = m[0]; op = o[3:0];
                            a = vals[i]; b = vals[j];
                            model(m[0], o[3:0], vals[i], vals[j], preset,
                                  e_res, e_wr, e_upd, e_fl);
                            #1;
                            chk(req_of(m[0], o[3:0]), "result", result, e_res);
                            chk(req_of(m[0], o[3:0]), "dest_we", {31'b0, dest_we}, {31'b0, e_wr});
                            chk(req_of(m[0], o[3:0]), "flags_we", {31'b0, flags_we}, {31'b0, e_upd});
                            chk(req_of(m[0], o[3:0]), "flags_new", {28'b0, flags_new}, {28'b0, e_fl});
                            @(posedge clk); #1;
                            chk("R11", "registered flags", {28'b0, flags}, {28'b0, e_fl});
                        end
                    end
                end
            end
        end
        @(negedge clk); cmd = 2'b00;
        finish_run();
    end

endmodule